// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Register

This block is a parallel-in, serial-out shift register with eight stages by default. It runs entirely in one fast system clock domain. The two shift-clock pins, the serial data pin and the active-low load control are each brought into that domain through a two-flop synchronizer. The two shift-clock pins are interchangeable and are combined as an OR of their levels. Either pin held high therefore inhibits shifting, and either pin held low lets the other one act as the shift clock.

A shift happens on the system clock cycle in which the combined level rises from low to high. The serial input enters the first stage, and every other stage takes the value of its neighbour nearer the input. While the synchronized load control is low, the parallel word is copied into the stages on every cycle. No edge is needed for this, and the load wins over any shift. The last stage drives a true output and a complementary output.

The edge detector keeps following the combined clock level for the whole time a load is held. Because of this, releasing the load never produces a stale shift. A synchronous active-high reset clears the stages and the edge history.

Top module: `piso_gated`

## Requirements
- R1: Stage i is loaded from `par_in[i]`. Stage 0 is the serial entry stage and stage N-1 drives `ser_out`. After a load and k shifts, `ser_out` shows `par_in[N-1-k]`.
- R2: On every cycle in which the synchronized `load_n` is 0, the stages take `par_in`. This holds whatever the clock pins are doing, and later changes of `par_in` are followed while the load is held.
- R3: While `load_n` is 1, changes on `par_in` have no effect on the stages.
- R4: A shift occurs when `sck_a` rises while `sck_b` is low, and equally when `sck_b` rises while `sck_a` is low.
- R5: While either clock pin is held high, toggling the other pin causes no shift. With both pins high, or with no rising edge of the combined level, the stages hold.
- R6: On a shift, the synchronized `ser_in` level enters stage 0. A bit shifted in appears on `ser_out` after N-1 further shifts.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: A rising clock edge that arrives while the load is held is never shifted once `load_n` returns to 1. The load wins over a shift in the same cycle.
- R9: A change on the pins reaches the stages on the third rising system clock edge after it is applied. The first two edges fill the synchronizer and the third updates the register.
- R10: A synchronous reset clears every stage and the edge history, so `ser_out` is 0 and `ser_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low level load control |
| sck_a | input | 1 | Shift clock / inhibit pin A |
| sck_b | input | 1 | Shift clock / inhibit pin B |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | N | Parallel word, bit i to stage i |
| ser_out | output | 1 | Last stage value |
| ser_out_n | output | 1 | Inverse of the last stage value |

## Verification
Directed patterns run first. One loads a known word and shifts it out, which separates a correct stage order from a reversed one. Another shifts a serial pattern through with the second clock pin, which shows that the pins are symmetric and that the serial input enters at the right end. Holding one pin high while the other toggles separates inhibit from clocking. Raising a clock pin during a held load and then releasing it exposes an edge history that stopped tracking. Seeded random steps then mix loads, edges, inhibits and parallel changes together. The bench model predicts the results, including a load being released in the same step as a clock edge.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Register action chosen each system clock cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } act_e;

    // Asynchronous control pins gathered for synchronization
    typedef struct packed {
        logic sck_a;
        logic sck_b;
        logic ser;
        logic load_n;
    } pins_t;

    localparam int SYNC_DEPTH = 2;

    // Reset value: clocks low, serial low, load inactive
    localparam pins_t PINS_RST = '{sck_a: 1'b0, sck_b: 1'b0, ser: 1'b0, load_n: 1'b1};

    // Load has priority over a detected shift edge
    function automatic act_e pick_act(input logic load_n, input logic fire);
        if (!load_n) begin
            return ACT_LOAD;
        end else if (fire) begin
            return ACT_SHIFT;
        end
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int           W       = 4,
    parameter int           DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/piso_edge.sv
module piso_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck_a,
    input  logic sck_b,
    output logic gate_lvl,
    output logic hist,
    output logic fire
);

    // Either pin high holds the combined level high (inhibit);
    // a pin held low passes the other pin through.
    assign gate_lvl = sck_a | sck_b;

    // History always follows the combined level, even during a load
    always_ff @(posedge clk) begin
        if (rst) hist <= 1'b0;
        else     hist <= gate_lvl;
    end

    assign fire = gate_lvl & ~hist;

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    input  logic         ser,
    input  logic [N-1:0] par,
    output logic [N-1:0] stage_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:  stage_q <= par;
                ACT_SHIFT: stage_q <= {stage_q[N-2:0], ser};
                default:   stage_q <= stage_q;
            endcase
        end
    end

endmodule

// File: rtl/piso_gated.sv
module piso_gated
    import piso_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         sck_a,
    input  logic         sck_b,
    input  logic         ser_in,
    input  logic [N-1:0] par_in,
    output logic         ser_out,
    output logic         ser_out_n
);

    localparam int PW  = $bits(pins_t);
    localparam int MSB = N - 1;

    pins_t        pins_raw;
    pins_t        pins_s;
    logic [PW-1:0] pins_s_vec;
    logic         gate_lvl;
    logic         hist;
    logic         fire;
    logic         load_s;
    logic         ser_s;
    act_e         act;
    logic [N-1:0] stage_q;

    always_comb begin
        pins_raw.sck_a  = sck_a;
        pins_raw.sck_b  = sck_b;
        pins_raw.ser    = ser_in;
        pins_raw.load_n = load_n;
    end

    piso_sync #(
        .W      (PW),
        .DEPTH  (SYNC_DEPTH),
        .RST_VAL(PINS_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins_raw),
        .q  (pins_s_vec)
    );

    assign pins_s = pins_t'(pins_s_vec);
    assign load_s = pins_s.load_n;
    assign ser_s  = pins_s.ser;

    piso_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sck_a   (pins_s.sck_a),
        .sck_b   (pins_s.sck_b),
        .gate_lvl(gate_lvl),
        .hist    (hist),
        .fire    (fire)
    );

    assign act = pick_act(load_s, fire);

    piso_stages #(.N(N)) u_stages (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .ser    (ser_s),
        .par    (par_in),
        .stage_q(stage_q)
    );

    assign ser_out   = stage_q[MSB];
    assign ser_out_n = ~stage_q[MSB];

endmodule

// File: rtl/piso_gated_chk.sv
module piso_gated_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_s,
    input logic         ser_s,
    input logic         gate_lvl,
    input logic         hist,
    input logic [N-1:0] par_in,
    input logic [N-1:0] stage_q
);

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        !load_s |=> stage_q == $past(par_in)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_s && gate_lvl && !hist) |=> stage_q == {$past(stage_q[N-2:0]), $past(ser_s)}); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (load_s && !(gate_lvl && !hist)) |=> $stable(stage_q)); // R5

    AST_HIST_TRACK: assert property (@(posedge clk) disable iff (rst)
        !load_s |=> hist == $past(gate_lvl)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (stage_q == '0 && !hist)); // R10

endmodule

bind piso_gated piso_gated_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_s  (load_s),
    .ser_s   (ser_s),
    .gate_lvl(gate_lvl),
    .hist    (hist),
    .par_in  (par_in),
    .stage_q (stage_q)
);

// File: tb/piso_gated_test.sv
module piso_gated_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         sck_a = 1'b0;
    logic         sck_b = 1'b0;
    logic         ser_in = 1'b0;
    logic [N-1:0] par_in = '0;
    logic         ser_out;
    logic         ser_out_n;

    logic [N-1:0] m = '0;
    int           total = 0;
    int           fails = 0;

    always #2 clk = ~clk;

    piso_gated #(.N(N)) uut (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .sck_a    (sck_a),
        .sck_b    (sck_b),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .ser_out  (ser_out),
        .ser_out_n(ser_out_n)
    );

    // Expected register after one settled step
    function automatic logic [N-1:0] next_model(
        input logic [N-1:0] cur, input logic pc, input logic nc,
        input logic pl, input logic nl, input logic ns, input logic [N-1:0] np);
        logic [N-1:0] r;
        r = cur;
        if (!pl) r = np;
        if (!nl)            r = np;
        else if (!pc && nc) r = {r[N-2:0], ns};
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act_v, input logic exp_v);
        total++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act_v, exp_v);
        end
    endtask

    // Outputs vs model, complement included (R7)
    task automatic check_out(input string req);
        check_bit(req, ser_out, m[N-1]);
        check_bit({req, "/R7"}, ser_out_n, ~m[N-1]);
    endtask

    task automatic drive(input logic na, input logic nb, input logic ns,
                         input logic nl, input logic [N-1:0] np, input string req);
        logic pc, pl;
        pc = sck_a | sck_b;
        pl = load_n;
        sck_a = na; sck_b = nb; ser_in = ns; load_n = nl; par_in = np;
        repeat (4) @(posedge clk);
        @(negedge clk);
        m = next_model(m, pc, na | nb, pl, nl, ns, np);
        check_out(req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        void'($urandom(32'd20240611));

        // R10: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m = '0;
        check_out("R10");

        // R9: three-edge latency of a load
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R2");
        par_in = 8'hFF;
        load_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_bit("R9", ser_out, 1'b0);
        @(posedge clk); @(negedge clk);
        check_bit("R9", ser_out, 1'b1);
        m = 8'hFF;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, "R2");

        // R1: stage order, shifting out a loaded word with sck_a
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R2");
        for (int k = 0; k < N; k++) begin
            check_bit("R1", ser_out, pat_bit(8'hA5, N - 1 - k));
            drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, "R4");
            drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R4");
        end

        // R6: serial entry, clocked by sck_b (R4 symmetry)
        pat = 8'b1011_0010;
        for (int k = 0; k < N; k++) begin
            drive(1'b0, 1'b1, pat[k], 1'b1, 8'h00, "R4");
            drive(1'b0, 1'b0, pat[k], 1'b1, 8'h00, "R4");
        end
        for (int k = 0; k < N; k++) begin
            check_bit("R6", ser_out, pat[k]);
            drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, "R6");
            drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R6");
        end

        // R5: inhibit by the other pin, then both high
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h80, "R2");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h80, "R4");
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h80, "R5");
            check_bit("R5", ser_out, 1'b0);
            drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h80, "R5");
        end
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h80, "R5");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h80, "R5");

        // R3: parallel changes ignored while load is inactive
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
        for (int k = 0; k < N; k++) begin
            check_bit("R3", ser_out, 1'b1);
            drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
            drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R3");
        end

        // R8: edge during load, released with the pin still high
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h80, "R2");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h80, "R8");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 8'h80, "R8");
        check_bit("R8", ser_out, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h80, "R8");
        check_bit("R8", ser_out, 1'b1);

        // Seeded random mix
        for (int s = 0; s < 300; s++) begin
            logic na, nb, ns, nl, pc;
            logic [N-1:0] np;
            string tag;
            na = 1'($urandom);
            nb = 1'($urandom);
            ns = 1'($urandom);
            nl = ($urandom % 4) != 0;
            np = N'($urandom);
            pc = sck_a | sck_b;
            if (!nl || !load_n)        tag = "R2";
            else if (!pc && (na | nb)) tag = "R4";
            else                       tag = "R5";
            drive(na, nb, ns, nl, np, tag);
        end

        summary();
        $finish;
    end

    function automatic logic pat_bit(input logic [N-1:0] w, input int i);
        return w[i];
    endfunction

endmodule